// File: doc/BRIEF.md
# Bus Error Status and Capture Unit

This unit sits beside the control logic of a PCI-style bus interface and watches one-cycle event strobes from it: the system-error and parity-error pins, the local data-parity checker, a select-timeout indication, a target-abort indication and an address-parity flag. It also watches the current role (initiator or target) and the transfer direction. From these it decides which of six error types occurred. It keeps each type as a sticky bit in a status register and drives an interrupt line while any bit is set.

A capture-disable register holds one bit per error type. The first error whose type is not disabled freezes the transaction address, the command nibble and the error type into capture registers, and raises a valid flag. Software reads the capture and writes 1 to the valid flag to arm capture again. A 2-bit word-addressed register port gives access to everything:

| Word | Register | Access |
|------|----------|--------|
| 0 | status | write 1 to clear |
| 1 | capture-disable mask | read/write |
| 2 | captured address | read only |
| 3 | capture info | bit 31 is write 1 to clear |

A two-state capture machine controls the capture:
- **ARMED** is the reset state. The transition *catch* goes from ARMED to HELD when an enabled error is seen, and it latches the capture.
- **HELD** keeps the capture frozen. The transition *release* goes back to ARMED when software writes 1 to the valid bit.

Top module: `bus_err_monitor`

## Requirements
- R1: After reset the status, disable mask, captured address and capture info all read 0, and `irq_o` is 0.
- R2: Error bits sit at these positions: address parity 10, system error 9, initiator parity 8, target parity 7, no response 6, target abort 5. All other status bits read 0. Only bits 10..5 of the disable mask are writable; a write of all ones reads back 0x7E0.
- R3: An `addr_par_err_i` strobe sets status bit 10. A `serr_i` strobe sets status bit 9 regardless of role or direction.
- R4: Initiator parity (bit 8) is set only in two cases, both in the initiator role: `perr_i` on a write, or `data_par_err_i` on a read. The two opposite pairings set nothing.
- R5: Target parity (bit 7) is set only in two cases, both in the target role: `perr_i` on a read, or `data_par_err_i` on a write.
- R6: In the initiator role, `devsel_timeout_i` sets bit 6 and `target_abort_i` sets bit 5. In the target role neither strobe sets anything.
- R7: Status bits are sticky and are cleared by writing 1 to word 0. Writing 0 has no effect. An error in the same cycle as its clear leaves the bit set.
- R8: In ARMED, the first enabled error sets the valid flag and records the values present in that cycle. Word 3 then reads: valid at bit 31, command nibble at bits 19:16, and error type as a one-hot at its status position. Word 2 holds the address.
- R9: In HELD, later errors update the status but never change the capture registers.
- R10: An error whose disable bit is 1 still sets its status bit. It neither catches nor blocks a later enabled error from being caught.
- R11: Writing 1 to word 3 bit 31 clears the valid flag and re-arms capture. An error in the same cycle as that write is not caught, but the next enabled error is.
- R12: When several enabled errors occur in the same cycle, the recorded type is the one with the highest bit index.
- R13: `irq_o` is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serr_i | input | 1 | System error pin strobe |
| perr_i | input | 1 | Parity error pin strobe |
| data_par_err_i | input | 1 | Local data parity checker failure |
| devsel_timeout_i | input | 1 | No target claimed the transfer |
| target_abort_i | input | 1 | Transfer ended in target abort |
| addr_par_err_i | input | 1 | Address parity failure |
| is_initiator_i | input | 1 | 1 when this side started the transfer |
| is_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Transfer address |
| bus_cmd_i | input | 4 | Command / byte-enable nibble |
| reg_addr_i | input | 2 | Register word select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| status_o | output | 32 | Sticky status register |
| cap_addr_o | output | ADDR_W | Captured address |
| cap_info_o | output | 32 | Capture info word |
| cap_valid_o | output | 1 | Capture valid flag |
| irq_o | output | 1 | Interrupt, any status bit set |

## Verification
The embedded assertions check, on every cycle, that status bits hold unless cleared (R7) and that a system-error strobe shows up in status one cycle later (R3). They also check that a held capture never moves (R9), that a fresh capture never carries a disabled type (R10), and that a valid capture holds exactly one type bit (R12). Only the directed scenarios can show the role/direction parity decoding (R4, R5, R6), the exact captured field values and which error wins, and the timing of re-arming when a clear and a new error meet in one cycle (R11).

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
    localparam int unsigned REG_W = 32;

    localparam int BIT_APAR  = 10;
    localparam int BIT_SERR  = 9;
    localparam int BIT_MPERR = 8;
    localparam int BIT_TPERR = 7;
    localparam int BIT_NORSP = 6;
    localparam int BIT_TABT  = 5;

    localparam logic [REG_W-1:0] ERR_FIELD_MASK = 32'h0000_07E0;

    localparam logic [1:0] OFS_STATUS  = 2'd0;
    localparam logic [1:0] OFS_DISABLE = 2'd1;
    localparam logic [1:0] OFS_CAPADDR = 2'd2;
    localparam logic [1:0] OFS_CAPINFO = 2'd3;

    localparam int INFO_VALID_BIT = 31;
    localparam int INFO_CMD_LSB   = 16;
    localparam int CMD_W          = 4;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;
endpackage

// File: rtl/err_detect.sv
module err_detect
    import bus_err_pkg::*;
(
    input  logic             serr_i,
    input  logic             perr_i,
    input  logic             data_par_err_i,
    input  logic             devsel_timeout_i,
    input  logic             target_abort_i,
    input  logic             addr_par_err_i,
    input  logic             is_initiator_i,
    input  logic             is_write_i,
    output logic [REG_W-1:0] ev_o
);
    always_comb begin
        ev_o = '0;
        ev_o[BIT_APAR]  = addr_par_err_i;
        ev_o[BIT_SERR]  = serr_i;
        ev_o[BIT_MPERR] = is_initiator_i &
                          ((perr_i & is_write_i) | (data_par_err_i & ~is_write_i));
        ev_o[BIT_TPERR] = ~is_initiator_i &
                          ((perr_i & ~is_write_i) | (data_par_err_i & is_write_i));
        ev_o[BIT_NORSP] = is_initiator_i & devsel_timeout_i;
        ev_o[BIT_TABT]  = is_initiator_i & target_abort_i;
    end
endmodule

// File: rtl/err_status.sv
module err_status
    import bus_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ev_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] status_o
);
    logic [REG_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_i) | ev_i) & ERR_FIELD_MASK;
    end

    assign status_o = status_q;

    // R7: bits not cleared stay set
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

    // R7: an event in the current cycle is set next cycle even under clear
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(ev_i & ERR_FIELD_MASK)) == $past(ev_i & ERR_FIELD_MASK)));
endmodule

// File: rtl/err_capture.sv
module err_capture
    import bus_err_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  ev_i,
    input  logic [REG_W-1:0]  disable_i,
    input  logic              rearm_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [REG_W-1:0]  type_o
);
    cap_state_e state_q, state_d;
    logic [REG_W-1:0]  cand, pick;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [REG_W-1:0]  type_q;
    logic              catch_now;

    assign cand = ev_i & ~disable_i & ERR_FIELD_MASK;

    // highest set index wins
    always_comb begin
        pick = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (cand[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        catch_now = 1'b0;
        unique case (state_q)
            CAP_ARMED: if (|cand) begin
                state_d   = CAP_HELD;
                catch_now = 1'b1;
            end
            CAP_HELD: if (rearm_i) state_d = CAP_ARMED;
            default: state_d = CAP_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            type_q <= '0;
        end else if (catch_now) begin
            addr_q <= addr_i;
            cmd_q  <= cmd_i;
            type_q <= pick;
        end
    end

    assign valid_o = (state_q == CAP_HELD);
    assign addr_o  = addr_q;
    assign cmd_o   = cmd_q;
    assign type_o  = type_q;

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_HELD) |=> ($stable(addr_q) && $stable(cmd_q) && $stable(type_q)));

    assert_no_disabled_catch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ((type_q & $past(disable_i)) == '0));

    assert_single_type_R12: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $onehot(type_q));
endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
    import bus_err_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serr_i,
    input  logic              perr_i,
    input  logic              data_par_err_i,
    input  logic              devsel_timeout_i,
    input  logic              target_abort_i,
    input  logic              addr_par_err_i,
    input  logic              is_initiator_i,
    input  logic              is_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [3:0]        bus_cmd_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_we_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [31:0]       status_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [31:0]       cap_info_o,
    output logic              cap_valid_o,
    output logic              irq_o
);
    logic [REG_W-1:0] ev, clr, status, disable_q, cap_type;
    logic [CMD_W-1:0] cap_cmd;
    logic             rearm;

    assign clr   = (reg_we_i && reg_addr_i == OFS_STATUS) ? reg_wdata_i : '0;
    assign rearm = reg_we_i && reg_addr_i == OFS_CAPINFO && reg_wdata_i[INFO_VALID_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)                                        disable_q <= '0;
        else if (reg_we_i && reg_addr_i == OFS_DISABLE)    disable_q <= reg_wdata_i & ERR_FIELD_MASK;
    end

    err_detect u_detect (
        .serr_i, .perr_i, .data_par_err_i, .devsel_timeout_i, .target_abort_i,
        .addr_par_err_i, .is_initiator_i, .is_write_i, .ev_o(ev)
    );

    err_status u_status (
        .clk, .rst_n, .ev_i(ev), .clr_i(clr), .status_o(status)
    );

    err_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk, .rst_n, .ev_i(ev), .disable_i(disable_q), .rearm_i(rearm),
        .addr_i(bus_addr_i), .cmd_i(bus_cmd_i), .valid_o(cap_valid_o),
        .addr_o(cap_addr_o), .cmd_o(cap_cmd), .type_o(cap_type)
    );

    always_comb begin
        cap_info_o = cap_type;
        cap_info_o[INFO_VALID_BIT] = cap_valid_o;
        cap_info_o[INFO_CMD_LSB +: CMD_W] = cap_cmd;
    end

    assign status_o = status;
    assign irq_o    = |status;

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            OFS_STATUS:  reg_rdata_o = status;
            OFS_DISABLE: reg_rdata_o = disable_q;
            OFS_CAPADDR: reg_rdata_o = REG_W'(cap_addr_o);
            OFS_CAPINFO: reg_rdata_o = cap_info_o;
            default:     reg_rdata_o = '0;
        endcase
    end

    assert_serr_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        serr_i |=> status_o[BIT_SERR]);

    assert_irq_tracks_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != '0) |-> irq_o);
endmodule

// File: tb/bus_err_monitor_test.sv
module bus_err_monitor_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic serr, perr, dpe, dto, tabt, apar, init, wr;
    logic [31:0] baddr;
    logic [3:0]  bcmd;
    logic [1:0]  raddr;
    logic        we;
    logic [31:0] wdata, rdata, status, cinfo, caddr;
    logic        cvalid, irq;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    bus_err_monitor uut (
        .clk, .rst_n, .serr_i(serr), .perr_i(perr), .data_par_err_i(dpe),
        .devsel_timeout_i(dto), .target_abort_i(tabt), .addr_par_err_i(apar),
        .is_initiator_i(init), .is_write_i(wr), .bus_addr_i(baddr), .bus_cmd_i(bcmd),
        .reg_addr_i(raddr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .status_o(status), .cap_addr_o(caddr), .cap_info_o(cinfo),
        .cap_valid_o(cvalid), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // flags: {apar, serr, perr, dpe, dto, tabt}
    task automatic drive_ev(input logic [5:0] f, input logic i, input logic w,
                            input logic [31:0] a, input logic [3:0] c);
        {apar, serr, perr, dpe, dto, tabt} = f;
        init = i; wr = w; baddr = a; bcmd = c;
    endtask

    task automatic idle_ev();
        {apar, serr, perr, dpe, dto, tabt} = '0;
        init = 1'b0; wr = 1'b0; baddr = '0; bcmd = '0;
    endtask

    task automatic fire(input logic [5:0] f, input logic i, input logic w,
                        input logic [31:0] a, input logic [3:0] c);
        @(negedge clk); drive_ev(f, i, w, a, c);
        @(negedge clk); idle_ev();
    endtask

    task automatic wreg(input logic [1:0] o, input logic [31:0] d);
        @(negedge clk); raddr = o; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] o, output logic [31:0] v);
        raddr = o; #1 v = rdata;
    endtask

    task automatic wipe();
        wreg(2'd0, 32'hFFFF_FFFF);
        wreg(2'd3, 32'h8000_0000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rreg(2'(k), v); chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        wreg(2'd1, 32'hFFFF_FFFF); rreg(2'd1, v); chk("R2 mask writable bits", v, 32'h7E0);
        wreg(2'd1, 32'h0);
        wreg(2'd0, 32'hFFFF_FFFF); rreg(2'd0, v); chk("R2 reserved status bits", v, 32'h0);
    endtask

    task automatic t_first_capture();
        logic [31:0] v;
        fire(6'b010000, 1'b1, 1'b1, 32'hA1A1_0004, 4'h7);
        rreg(2'd0, v); chk("R3 serr bit 9", v, 32'h200);
        chk("R13 irq on status", {31'b0, irq}, 32'h1);
        rreg(2'd2, v); chk("R8 captured address", v, 32'hA1A1_0004);
        rreg(2'd3, v); chk("R8 capture info", v, 32'h8007_0200);
        fire(6'b100000, 1'b0, 1'b0, 32'hB2B2_0008, 4'h2);
        rreg(2'd0, v); chk("R3 apar bit 10", v, 32'h600);
        rreg(2'd2, v); chk("R9 address held", v, 32'hA1A1_0004);
        rreg(2'd3, v); chk("R9 info held", v, 32'h8007_0200);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wreg(2'd0, 32'h0);   rreg(2'd0, v); chk("R7 write 0 no effect", v, 32'h600);
        wreg(2'd0, 32'h200); rreg(2'd0, v); chk("R7 clear one bit", v, 32'h400);
        wreg(2'd0, 32'h400); rreg(2'd0, v); chk("R7 clear last bit", v, 32'h0);
        chk("R13 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk); raddr = 2'd0; wdata = 32'h200; we = 1'b1;
        drive_ev(6'b010000, 1'b0, 1'b0, 32'h0, 4'h0);
        @(negedge clk); we = 1'b0; idle_ev();
        rreg(2'd0, v); chk("R7 new error beats clear", v, 32'h200);
        wreg(2'd3, 32'h8000_0000);
        rreg(2'd3, v); chk("R11 valid cleared", v & 32'h8000_0000, 32'h0);
    endtask

    task automatic expect_bits(input string req, input logic [5:0] f, input logic i,
                               input logic w, input logic [31:0] exp);
        logic [31:0] v;
        wreg(2'd0, 32'hFFFF_FFFF);
        fire(f, i, w, 32'h0, 4'h0);
        rreg(2'd0, v); chk(req, v, exp);
    endtask

    task automatic t_decode();
        expect_bits("R4 init write perr", 6'b001000, 1'b1, 1'b1, 32'h100);
        expect_bits("R4 init read dpe",   6'b000100, 1'b1, 1'b0, 32'h100);
        expect_bits("R4 init write dpe",  6'b000100, 1'b1, 1'b1, 32'h0);
        expect_bits("R4 init read perr",  6'b001000, 1'b1, 1'b0, 32'h0);
        expect_bits("R5 tgt read perr",   6'b001000, 1'b0, 1'b0, 32'h080);
        expect_bits("R5 tgt write dpe",   6'b000100, 1'b0, 1'b1, 32'h080);
        expect_bits("R5 tgt read dpe",    6'b000100, 1'b0, 1'b0, 32'h0);
        expect_bits("R6 init timeout",    6'b000010, 1'b1, 1'b0, 32'h040);
        expect_bits("R6 init abort",      6'b000001, 1'b1, 1'b0, 32'h020);
        expect_bits("R6 tgt ignored",     6'b000011, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wipe();
        wreg(2'd1, 32'h200);
        fire(6'b010000, 1'b1, 1'b0, 32'hC0C0_0010, 4'h5);
        rreg(2'd0, v); chk("R10 disabled still sets status", v, 32'h200);
        chk("R10 disabled not caught", {31'b0, cvalid}, 32'h0);
        fire(6'b000001, 1'b1, 1'b0, 32'hD0D0_0020, 4'h3);
        rreg(2'd3, v); chk("R10 later enabled caught", v, 32'h8003_0020);
        rreg(2'd2, v); chk("R10 later address", v, 32'hD0D0_0020);
        wreg(2'd1, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wipe();
        fire(6'b010011, 1'b1, 1'b0, 32'h0000_0100, 4'h1);
        rreg(2'd3, v); chk("R12 highest wins", v, 32'h8001_0200);
        wipe();
        wreg(2'd1, 32'h200);
        fire(6'b010011, 1'b1, 1'b0, 32'h0000_0200, 4'h1);
        rreg(2'd3, v); chk("R12 highest enabled wins", v, 32'h8001_0040);
        wreg(2'd1, 32'h0);
    endtask

    task automatic t_rearm_race();
        logic [31:0] v;
        wipe();
        fire(6'b000001, 1'b1, 1'b0, 32'h0000_0300, 4'h9);
        @(negedge clk); raddr = 2'd3; wdata = 32'h8000_0000; we = 1'b1;
        drive_ev(6'b010000, 1'b1, 1'b0, 32'h0000_0400, 4'hA);
        @(negedge clk); we = 1'b0; idle_ev();
        chk("R11 error during release not caught", {31'b0, cvalid}, 32'h0);
        fire(6'b100000, 1'b0, 1'b0, 32'h0000_0500, 4'hB);
        rreg(2'd3, v); chk("R11 next error caught", v, 32'h800B_0400);
        rreg(2'd2, v); chk("R11 next address", v, 32'h0000_0500);
    endtask

    initial begin
        idle_ev(); raddr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_first_capture();
        t_w1c();
        t_decode();
        t_disable();
        t_priority();
        t_rearm_race();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule